// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block emits exactly one pulse per accepted trigger edge. A selectable transition on an asynchronous trigger input is synchronized and then qualified. If the block is idle, the qualified edge zeroes a 16-bit up-counter and starts it. The output flip-flop leaves its programmed idle level when the count reaches a start-compare value. It returns to the idle level when the count reaches an end-compare value. At that point the counter stops and the block is ready again.

While a pulse is being timed, the block ignores every further trigger transition. Each compare match produces a single-cycle strobe. An output-enable bit gates the pin without disturbing the timing logic.

Top module: `ospt_timer`

## Requirements
- R1: During and after a synchronous reset, `busy`, `startHit` and `endHit` are 0, and `pulseOut` equals `idleLevel` when `outEn` is 1.
- R2: `edgeSel` picks the qualifying trigger edge as follows: 2'b00 is falling, 2'b01 is rising, 2'b11 is both, and 2'b10 accepts no edge.
- R3: If a qualifying change of `trigIn` is set up before clock edge k while the block is idle, then `busy` reads 1 after edge k+2 and the internal count restarts from zero.
- R4: With start value S, `pulseOut` takes the active level (the inverse of `idleLevel`) after edge k+3+S. `startHit` is high for exactly that one cycle.
- R5: With end value T, `pulseOut` returns to `idleLevel` after edge k+3+T. `endHit` is high for exactly that one cycle, and `busy` reads 0 from then on.
- R6: Trigger transitions of any kind that arrive while `busy` is 1 neither restart nor lengthen the pulse.
- R7: With `outEn` at 0, `pulseOut` is 0, while counting and the output flip-flop keep operating. Setting `outEn` in mid-pulse shows the active level at once.
- R8: The idle level of the pulse is taken from `idleLevel`; with `idleLevel` = 1 the pulse is low-going.
- R9: After the end match, a new qualifying edge starts a new pulse with the same timing as R3 to R5.
- R10: The configuration must satisfy 0 <= S < T <= 0xFFFF. S = 0 is legal and activates the output one cycle after `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Asynchronous trigger input |
| edgeSel | input | 2 | Qualifying edge selection (see R2) |
| cmpStart | input | 16 | Count at which the pulse becomes active |
| cmpEnd | input | 16 | Count at which the pulse ends |
| outEn | input | 1 | Pin drive enable; pin is 0 when clear |
| idleLevel | input | 1 | Level of the output flip-flop outside a pulse |
| pulseOut | output | 1 | Pulse pin |
| busy | output | 1 | High while a pulse is being timed |
| startHit | output | 1 | One-cycle strobe on start match |
| endHit | output | 1 | One-cycle strobe on end match |

## Verification
Several faults show up directly on the pins:
- A wrong synchronizer depth or a wrong counter clear shifts every edge of `pulseOut` and `busy` by whole cycles, and does so on the first triggered pulse.
- A busy flag that fails to drop or to hold shows up as a missing second pulse, or as a pulse whose end moves when the trigger toggles during it. This is visible within one pulse length.
- A wrong edge decode gives a pulse where none is expected, or none where one is, three cycles after the stimulus.
- A flip-flop stopped by the output gate shows up when `outEn` is raised mid-pulse.

// File: rtl/ospt_pkg.sv
package ospt_pkg;
  typedef struct packed {
    logic clear;
    logic run;
  } ctrlStrobe_t;

  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_NONE = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/ospt_ctrl.sv
module ospt_ctrl
  import ospt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trigIn,
  input  logic [1:0]  edgeSel,
  input  logic        endMatch,
  output ctrlStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          busyQ;
  logic          riseEdge, fallEdge, validEdge, accept;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= trigIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[LAST-1:0], trigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= syncQ[LAST];
  end

  assign riseEdge = syncQ[LAST] & ~prevQ;
  assign fallEdge = ~syncQ[LAST] & prevQ;

  always_comb begin
    case (edgeSel)
      EDGE_FALL: validEdge = fallEdge;
      EDGE_RISE: validEdge = riseEdge;
      EDGE_BOTH: validEdge = riseEdge | fallEdge;
      default:   validEdge = 1'b0;
    endcase
  end

  assign accept = validEdge & ~busyQ;

  always_ff @(posedge clk) begin
    if (rst)           busyQ <= 1'b0;
    else if (accept)   busyQ <= 1'b1;
    else if (endMatch) busyQ <= 1'b0;
  end

  assign strobe.clear = accept;
  assign strobe.run   = busyQ;

  // R3
  busy_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busyQ) |-> $past(validEdge));

  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !endMatch) |=> busyQ);
endmodule

// File: rtl/ospt_dpath.sv
module ospt_dpath
  import ospt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobe_t  strobe,
  input  logic [W-1:0] cmpStart,
  input  logic [W-1:0] cmpEnd,
  input  logic         idleLevel,
  output logic         outLevel,
  output logic         endMatch,
  output logic         startHit,
  output logic         endHit
);
  logic [W-1:0] cntQ;
  logic         startMatch;

  assign startMatch = strobe.run && (cntQ == cmpStart);
  assign endMatch   = strobe.run && (cntQ == cmpEnd);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= '0;
      outLevel <= idleLevel;
      startHit <= 1'b0;
      endHit   <= 1'b0;
    end else begin
      startHit <= startMatch;
      endHit   <= endMatch;
      if (strobe.clear)                cntQ <= '0;
      else if (strobe.run && !endMatch) cntQ <= cntQ + 1'b1;
      if (endMatch)        outLevel <= idleLevel;
      else if (startMatch) outLevel <= ~idleLevel;
      else if (!strobe.run) outLevel <= idleLevel;
    end
  end

  // R3
  count_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.run) |-> (cntQ == '0));

  // R4
  start_active_chk: assert property (@(posedge clk) disable iff (rst)
    startHit |-> (outLevel != $past(idleLevel)));

  // R5
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    endHit |-> (!strobe.run && outLevel == $past(idleLevel)));

  // R10
  strobes_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpStart < cmpEnd) |-> $onehot0({startHit, endHit}));
endmodule

// File: rtl/ospt_timer.sv
module ospt_timer
  import ospt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trigIn,
  input  logic [1:0]   edgeSel,
  input  logic [W-1:0] cmpStart,
  input  logic [W-1:0] cmpEnd,
  input  logic         outEn,
  input  logic         idleLevel,
  output logic         pulseOut,
  output logic         busy,
  output logic         startHit,
  output logic         endHit
);
  ctrlStrobe_t strobe;
  logic        endMatch;
  logic        outLevel;

  ospt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .edgeSel(edgeSel),
    .endMatch(endMatch), .strobe(strobe)
  );

  ospt_dpath #(.W(W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .cmpStart(cmpStart),
    .cmpEnd(cmpEnd), .idleLevel(idleLevel), .outLevel(outLevel),
    .endMatch(endMatch), .startHit(startHit), .endHit(endHit)
  );

  assign pulseOut = outEn & outLevel;
  assign busy     = strobe.run;
endmodule

// File: tb/ospt_timer_tb.sv
`timescale 1ns/1ps
module ospt_timer_tb_top;
  import ospt_pkg::*;

  typedef struct packed {
    logic [1:0] sel;
    logic       fromLvl;
    logic       toLvl;
    logic [7:0] s;
    logic [7:0] t;
    logic       en;
    logic       idl;
    logic       trig;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 1'b0, 1'b1, 8'd2, 8'd5, 1'b1, 1'b0, 1'b1},
    '{2'b00, 1'b1, 1'b0, 8'd0, 8'd3, 1'b1, 1'b0, 1'b1},
    '{2'b11, 1'b0, 1'b1, 8'd4, 8'd9, 1'b1, 1'b1, 1'b1},
    '{2'b11, 1'b1, 1'b0, 8'd1, 8'd2, 1'b1, 1'b0, 1'b1},
    '{2'b01, 1'b1, 1'b0, 8'd2, 8'd5, 1'b1, 1'b0, 1'b0},
    '{2'b00, 1'b0, 1'b1, 8'd2, 8'd5, 1'b1, 1'b0, 1'b0},
    '{2'b10, 1'b0, 1'b1, 8'd2, 8'd5, 1'b1, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b1, 8'd3, 8'd7, 1'b0, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trigIn = 1'b0;
  logic [1:0]  edgeSel = EDGE_NONE;
  logic [15:0] cmpStart = 16'd2;
  logic [15:0] cmpEnd = 16'd5;
  logic        outEn = 1'b1;
  logic        idleLevel = 1'b1;
  logic        pulseOut, busy, startHit, endHit;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  summaryDone = 1'b0;

  always #5 clk = ~clk;

  ospt_timer dut_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .edgeSel(edgeSel),
    .cmpStart(cmpStart), .cmpEnd(cmpEnd), .outEn(outEn),
    .idleLevel(idleLevel), .pulseOut(pulseOut), .busy(busy),
    .startHit(startHit), .endHit(endHit)
  );

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input logic act,
                     input logic exp, input int n);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at step %0d: actual %b expected %b", req, what, n, act, exp);
    end
  endtask

  // Expected view after clock edge n counted from the trigger set-up (edge 1 = k)
  task automatic checkCycle(input int n, input int s, input int t, input logic en,
                            input logic idl, input logic trig);
    logic bExp, aExp, pExp, shExp, ehExp;
    bExp  = trig && (n >= 3) && (n < 4 + t);
    aExp  = trig && (n >= 4 + s) && (n < 4 + t);
    pExp  = en ? (aExp ? ~idl : idl) : 1'b0;
    shExp = trig && (n == 4 + s);
    ehExp = trig && (n == 4 + t);
    if (!trig) begin
      chk("R2", "busy", busy, 1'b0, n);
      chk("R2", "pulseOut", pulseOut, pExp, n);
    end else begin
      chk("R3", "busy", busy, bExp, n);
      if (!en)      chk("R7", "pulseOut", pulseOut, pExp, n);
      else if (idl) chk("R8", "pulseOut", pulseOut, pExp, n);
      else          chk("R4", "pulseOut", pulseOut, pExp, n);
      chk("R4", "startHit", startHit, shExp, n);
      chk("R5", "endHit", endHit, ehExp, n);
    end
  endtask

  task automatic prep(input logic fromLvl, input logic [1:0] sel, input int s,
                      input int t, input logic en, input logic idl);
    edgeSel   = EDGE_NONE;
    trigIn    = fromLvl;
    cmpStart  = 16'(s);
    cmpEnd    = 16'(t);
    outEn     = en;
    idleLevel = idl;
    repeat (5) @(negedge clk);
    edgeSel = sel;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "pulseOut", pulseOut, 1'b1, 0);
    chk("R1", "busy", busy, 1'b0, 0);
    chk("R1", "startHit", startHit, 1'b0, 0);
    chk("R1", "endHit", endHit, 1'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    idleLevel = 1'b0;
    @(negedge clk);
    chk("R8", "idle pulseOut", pulseOut, 1'b0, 0);

    // table walk: R2, R3, R4, R5, R7, R8, R10 (S = 0 row)
    for (int v = 0; v < NV; v++) begin
      prep(TBL[v].fromLvl, TBL[v].sel, int'(TBL[v].s), int'(TBL[v].t),
           TBL[v].en, TBL[v].idl);
      trigIn = TBL[v].toLvl;
      for (int n = 1; n <= int'(TBL[v].t) + 8; n++) begin
        @(negedge clk);
        checkCycle(n, int'(TBL[v].s), int'(TBL[v].t), TBL[v].en,
                   TBL[v].idl, TBL[v].trig);
      end
    end

    // R6: retriggers during a pulse are ignored
    prep(1'b0, EDGE_BOTH, 5, 20, 1'b1, 1'b0);
    trigIn = 1'b1;
    for (int n = 1; n <= 28; n++) begin
      @(negedge clk);
      checkCycle(n, 5, 20, 1'b1, 1'b0, 1'b1);
      if (n == 6 || n == 8 || n == 10 || n == 12) trigIn = ~trigIn;
    end
    chk("R6", "busy after end", busy, 1'b0, 28);

    // R9: ready for a new trigger after the end match
    repeat (3) @(negedge clk);
    cmpStart = 16'd1;
    cmpEnd   = 16'd3;
    @(negedge clk);
    trigIn = 1'b0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      checkCycle(n, 1, 3, 1'b1, 1'b0, 1'b1);
      if (n == 3) chk("R9", "busy restart", busy, 1'b1, n);
    end

    // R7: flip-flop keeps running while the pin is gated
    prep(1'b0, EDGE_RISE, 2, 8, 1'b0, 1'b0);
    trigIn = 1'b1;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (n < 7) checkCycle(n, 2, 8, 1'b0, 1'b0, 1'b1);
      else       checkCycle(n, 2, 8, 1'b1, 1'b0, 1'b1);
      if (n == 6) begin
        outEn = 1'b1;
        #1;
        chk("R7", "pulseOut after enable", pulseOut, 1'b1, n);
      end
    end

    summary();
  end
endmodule